// File: doc/BRIEF.md
# XOR-Tag Butterfly Router

This block is an eight-terminal, three-stage butterfly network built from 2x2 switching elements. A packet offered on an input line carries a source terminal number, a destination terminal number and a payload. Its routing tag is the bitwise XOR of source and destination. At each stage the packet either stays on its line or moves to the partner line, which differs from the current line in exactly the bit that the stage owns. If the source field equals the input line number, the packet leaves on the output line given by its destination.

Each stage is followed by one register, so every packet spends the same fixed number of cycles in the network. The network can block. When two packets want the same internal link, the packet going straight keeps it. The crossing packet is discarded, and a blocked flag is raised for the input line it came from. That flag appears in the same cycle in which the packet would otherwise have been delivered. Nothing is buffered or retried; resubmitting a blocked packet is left to the sender.

Top module: `bfly_xor_router`

## Requirements
- R1: While reset is high, and in the first cycle after it, every `out_valid` bit and every `blocked` bit is 0.
- R2: The routing tag is `src ^ dst`. A packet offered on input line p leaves on output line `p ^ src ^ dst`. When `src == p`, that line is `dst`. For example, a packet from terminal 4 (100) to terminal 6 (110) has tag 010 and leaves on output 6.
- R3: Stage s (s = 0, 1, 2) uses tag bit s. If that bit is 0, the packet stays on its line. If it is 1, the packet moves to the line whose number differs only in bit s.
- R4: A packet offered in cycle k is presented on its output line after the third rising clock edge that follows. `src`, `dst` and the payload arrive unchanged.
- R5: When a straight-going packet and a crossing packet want the same stage output, the straight-going packet proceeds and the crossing packet is discarded.
- R6: For each discarded packet, `blocked[p]` (p = its input line) is 1 for exactly one cycle, the cycle in which the packet would otherwise have been delivered. In every cycle, the number of delivered packets plus the number of blocked flags equals the number of packets offered three cycles earlier.
- R7: A packet with `src == dst` has an all-zero tag. It stays on its line through every stage and is never blocked.
- R8: Packets that all carry the same tag never collide, and all of them are delivered, including when all eight lines are busy.
- R9: Two packets on partner lines that both cross at a stage swap lines without blocking.
- R10: An input line whose `in_valid` is 0 contributes no output and no blocked flag, whatever its other fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 8 | Packet present on each input line |
| in_src | input | 24 | Source terminal per line, 3 bits each, line p at bits [3p+2:3p] |
| in_dst | input | 24 | Destination terminal per line, same packing |
| in_data | input | 8*DATA_W | Payload per line, line p at [DATA_W*p +: DATA_W] |
| out_valid | output | 8 | Packet delivered on each output line |
| out_src | output | 24 | Source field of delivered packet |
| out_dst | output | 24 | Destination field of delivered packet |
| out_data | output | 8*DATA_W | Payload of delivered packet |
| blocked | output | 8 | Per input line: its packet was discarded in a collision |

## Verification
The hardest case to reach from the ports is a collision at a chosen stage, because two packets only meet if their lines and tags agree at every earlier stage. The stimulus pairs a packet that goes straight with a second packet whose tag has a single 1, placed in bit 0, 1 or 2. This forces one collision at each stage, and the bench checks which line is flagged and which payload survives. A full load with one common tag, and a pair that swaps lines, confirm that traffic which must not block does not block.

// File: rtl/bfly_pkg.sv
package bfly_pkg;
    localparam int ADDR_W = 3;
    localparam int LINES  = 1 << ADDR_W;

    typedef logic [ADDR_W-1:0] term_t;

    typedef struct packed {
        logic  valid;
        term_t src;
        term_t dst;
        term_t origin;
    } hdr_t;

    function automatic term_t route_tag(term_t s, term_t d);
        return s ^ d;
    endfunction
endpackage

// File: rtl/bfly_switch2.sv
module bfly_switch2
    import bfly_pkg::*;
#(
    parameter int STAGE  = 0,
    parameter int DATA_W = 16
) (
    input  hdr_t              lo_hdr,
    input  logic [DATA_W-1:0] lo_dat,
    input  hdr_t              hi_hdr,
    input  logic [DATA_W-1:0] hi_dat,
    output hdr_t              olo_hdr,
    output logic [DATA_W-1:0] olo_dat,
    output hdr_t              ohi_hdr,
    output logic [DATA_W-1:0] ohi_dat,
    output logic              drop_lo,
    output logic              drop_hi
);
    term_t tag_lo, tag_hi;
    logic  lo_str, lo_crs, hi_str, hi_crs;

    always_comb begin
        tag_lo = route_tag(lo_hdr.src, lo_hdr.dst);
        tag_hi = route_tag(hi_hdr.src, hi_hdr.dst);
        lo_str = lo_hdr.valid && !tag_lo[STAGE];
        lo_crs = lo_hdr.valid &&  tag_lo[STAGE];
        hi_str = hi_hdr.valid && !tag_hi[STAGE];
        hi_crs = hi_hdr.valid &&  tag_hi[STAGE];

        olo_hdr = '0;
        olo_dat = '0;
        if (lo_str) begin
            olo_hdr = lo_hdr;
            olo_dat = lo_dat;
        end else if (hi_crs) begin
            olo_hdr = hi_hdr;
            olo_dat = hi_dat;
        end

        ohi_hdr = '0;
        ohi_dat = '0;
        if (hi_str) begin
            ohi_hdr = hi_hdr;
            ohi_dat = hi_dat;
        end else if (lo_crs) begin
            ohi_hdr = lo_hdr;
            ohi_dat = lo_dat;
        end

        drop_lo = lo_crs && hi_str;
        drop_hi = hi_crs && lo_str;
    end
endmodule

// File: rtl/bfly_stage.sv
module bfly_stage
    import bfly_pkg::*;
#(
    parameter int STAGE  = 0,
    parameter int DATA_W = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  hdr_t [LINES-1:0]             in_hdr,
    input  logic [LINES-1:0][DATA_W-1:0] in_dat,
    input  logic [LINES-1:0]             in_blk,
    output hdr_t [LINES-1:0]             out_hdr,
    output logic [LINES-1:0][DATA_W-1:0] out_dat,
    output logic [LINES-1:0]             out_blk
);
    localparam int PAIRS = LINES / 2;
    localparam int SBIT  = 1 << STAGE;

    hdr_t [LINES-1:0]             nxt_hdr;
    logic [LINES-1:0][DATA_W-1:0] nxt_dat;
    logic [LINES-1:0]             drop_line;
    logic [LINES-1:0]             nxt_blk;
    term_t                        line_tag [LINES];

    for (genvar p = 0; p < PAIRS; p++) begin : g_sw
        localparam int LO = ((p >> STAGE) << (STAGE + 1)) | (p & (SBIT - 1));
        localparam int HI = LO | SBIT;
        bfly_switch2 #(.STAGE(STAGE), .DATA_W(DATA_W)) u_sw (
            .lo_hdr  (in_hdr[LO]),
            .lo_dat  (in_dat[LO]),
            .hi_hdr  (in_hdr[HI]),
            .hi_dat  (in_dat[HI]),
            .olo_hdr (nxt_hdr[LO]),
            .olo_dat (nxt_dat[LO]),
            .ohi_hdr (nxt_hdr[HI]),
            .ohi_dat (nxt_dat[HI]),
            .drop_lo (drop_line[LO]),
            .drop_hi (drop_line[HI])
        );
    end

    always_comb begin
        nxt_blk = in_blk;
        for (int j = 0; j < LINES; j++) begin
            line_tag[j] = route_tag(in_hdr[j].src, in_hdr[j].dst);
            if (drop_line[j]) nxt_blk[in_hdr[j].origin] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_hdr <= '0;
            out_dat <= '0;
            out_blk <= '0;
        end else begin
            out_hdr <= nxt_hdr;
            out_dat <= nxt_dat;
            out_blk <= nxt_blk;
        end
    end

    for (genvar j = 0; j < LINES; j++) begin : g_chk
        localparam int PART = j ^ SBIT;

        AST_STRAIGHT_HOLDS: assert property (@(posedge clk) disable iff (rst)
            (in_hdr[j].valid && !line_tag[j][STAGE]) |=>
            (out_hdr[j].valid && out_hdr[j].origin == $past(in_hdr[j].origin))); // R5

        AST_CROSS_MOVES: assert property (@(posedge clk) disable iff (rst)
            (in_hdr[j].valid && line_tag[j][STAGE] &&
             !(in_hdr[PART].valid && !line_tag[PART][STAGE])) |=>
            (out_hdr[PART].valid && out_hdr[PART].origin == $past(in_hdr[j].origin))); // R3
    end
endmodule

// File: rtl/bfly_xor_router.sv
module bfly_xor_router
    import bfly_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [LINES-1:0]          in_valid,
    input  logic [LINES*ADDR_W-1:0]   in_src,
    input  logic [LINES*ADDR_W-1:0]   in_dst,
    input  logic [LINES*DATA_W-1:0]   in_data,
    output logic [LINES-1:0]          out_valid,
    output logic [LINES*ADDR_W-1:0]   out_src,
    output logic [LINES*ADDR_W-1:0]   out_dst,
    output logic [LINES*DATA_W-1:0]   out_data,
    output logic [LINES-1:0]          blocked
);
    localparam int STAGES = ADDR_W;

    hdr_t [LINES-1:0]             hdr_s [STAGES+1];
    logic [LINES-1:0][DATA_W-1:0] dat_s [STAGES+1];
    logic [LINES-1:0]             blk_s [STAGES+1];

    always_comb begin
        for (int p = 0; p < LINES; p++) begin
            hdr_s[0][p].valid  = in_valid[p];
            hdr_s[0][p].src    = in_src[p*ADDR_W +: ADDR_W];
            hdr_s[0][p].dst    = in_dst[p*ADDR_W +: ADDR_W];
            hdr_s[0][p].origin = term_t'(p);
            dat_s[0][p]        = in_data[p*DATA_W +: DATA_W];
        end
        blk_s[0] = '0;
    end

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        bfly_stage #(.STAGE(s), .DATA_W(DATA_W)) u_stage (
            .clk     (clk),
            .rst     (rst),
            .in_hdr  (hdr_s[s]),
            .in_dat  (dat_s[s]),
            .in_blk  (blk_s[s]),
            .out_hdr (hdr_s[s+1]),
            .out_dat (dat_s[s+1]),
            .out_blk (blk_s[s+1])
        );
    end

    always_comb begin
        for (int j = 0; j < LINES; j++) begin
            out_valid[j]                 = hdr_s[STAGES][j].valid;
            out_src[j*ADDR_W +: ADDR_W]  = hdr_s[STAGES][j].src;
            out_dst[j*ADDR_W +: ADDR_W]  = hdr_s[STAGES][j].dst;
            out_data[j*DATA_W +: DATA_W] = dat_s[STAGES][j];
        end
        blocked = blk_s[STAGES];
    end

    logic [1:0] warm;
    always_ff @(posedge clk) begin
        if (rst)               warm <= '0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    AST_CONSERVE: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd3) |->
        ($countones(out_valid) + $countones(blocked) == $countones($past(in_valid, 3)))); // R6

    for (genvar j = 0; j < LINES; j++) begin : g_line
        AST_LINE_MATCH: assert property (@(posedge clk) disable iff (rst)
            out_valid[j] |->
            (term_t'(j) == (hdr_s[STAGES][j].origin ^ hdr_s[STAGES][j].src ^ hdr_s[STAGES][j].dst))); // R2
    end
endmodule

// File: tb/bfly_xor_router_test.sv
module bfly_xor_router_test;
    localparam int N  = 8;
    localparam int AW = 3;
    localparam int DW = 16;

    logic            clk = 1'b0;
    logic            rst;
    logic [N-1:0]    in_valid;
    logic [N*AW-1:0] in_src, in_dst;
    logic [N*DW-1:0] in_data;
    logic [N-1:0]    out_valid;
    logic [N*AW-1:0] out_src, out_dst;
    logic [N*DW-1:0] out_data;
    logic [N-1:0]    blocked;

    int checks   = 0;
    int failures = 0;

    always #4 clk = ~clk;

    bfly_xor_router #(.DATA_W(DW)) uut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_src(in_src), .in_dst(in_dst), .in_data(in_data),
        .out_valid(out_valid), .out_src(out_src), .out_dst(out_dst),
        .out_data(out_data), .blocked(blocked)
    );

    task automatic clear_in();
        in_valid = '0; in_src = '0; in_dst = '0; in_data = '0;
    endtask

    task automatic offer(int p, int s, int d, logic [DW-1:0] v);
        in_valid[p] = 1'b1;
        in_src[p*AW +: AW] = AW'(s);
        in_dst[p*AW +: AW] = AW'(d);
        in_data[p*DW +: DW] = v;
    endtask

    // Inputs are set at a falling edge; the third rising edge after that presents the result.
    task automatic run_to_output();
        @(posedge clk); #1; clear_in();
        @(posedge clk);
        @(posedge clk); #1;
    endtask

    task automatic check_line(int j, bit ev, logic [DW-1:0] ed, string req);
        checks++;
        if (out_valid[j] !== ev || (ev && out_data[j*DW +: DW] !== ed)) begin
            failures++;
            $display("FAIL %s line %0d: valid=%b data=%h expected valid=%b data=%h",
                     req, j, out_valid[j], out_data[j*DW +: DW], ev, ed);
        end
    endtask

    task automatic check_blk(logic [N-1:0] exp_b, string req);
        checks++;
        if (blocked !== exp_b) begin
            failures++;
            $display("FAIL %s blocked=%b expected %b", req, blocked, exp_b);
        end
    endtask

    task automatic check_idle(string req);
        checks++;
        if (out_valid !== '0 || blocked !== '0) begin
            failures++;
            $display("FAIL %s out_valid=%b blocked=%b expected 0 and 0", req, out_valid, blocked);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; clear_in();
        in_valid = '1;
        repeat (3) @(posedge clk);
        #1; check_idle("R1 during reset");
        @(negedge clk); rst = 1'b0; clear_in();
        @(posedge clk); #1; check_idle("R1 first cycle after reset");
    endtask

    task automatic t_example();
        @(negedge clk); offer(4, 4, 6, 16'hA406);
        run_to_output();
        check_line(6, 1'b1, 16'hA406, "R2 4->6 on line 6");
        check_line(4, 1'b0, '0, "R3 no copy left on line 4");
        checks++;
        if (out_src[6*AW +: AW] !== 3'd4 || out_dst[6*AW +: AW] !== 3'd6) begin
            failures++;
            $display("FAIL R4 header src=%0d dst=%0d expected 4 6",
                     out_src[6*AW +: AW], out_dst[6*AW +: AW]);
        end
        check_blk('0, "R4 no block");
        @(posedge clk); #1; check_idle("R4 single cycle presentation");
    endtask

    task automatic t_self();
        @(negedge clk); offer(5, 5, 5, 16'h5555);
        run_to_output();
        check_line(5, 1'b1, 16'h5555, "R7 src==dst stays");
        check_blk('0, "R7 not blocked");
    endtask

    task automatic t_src_mismatch();
        @(negedge clk); offer(3, 0, 0, 16'h3000);
        run_to_output();
        check_line(3, 1'b1, 16'h3000, "R2 line = port ^ tag");
    endtask

    task automatic t_collide(int stage_bit);
        int w, l;
        w = 0; l = 1 << stage_bit;
        @(negedge clk);
        offer(w, w, w, 16'hB000 + 16'(stage_bit));
        offer(l, l, w, 16'hC000 + 16'(stage_bit));
        run_to_output();
        check_line(w, 1'b1, 16'hB000 + 16'(stage_bit), "R5 straight wins");
        check_line(l, 1'b0, '0, "R5 loser gone");
        check_blk(N'(1 << l), "R6 loser flagged");
        @(posedge clk); #1; check_blk('0, "R6 one-cycle flag");
    endtask

    task automatic t_full_load(int t);
        @(negedge clk);
        for (int p = 0; p < N; p++) offer(p, p, p ^ t, 16'hD000 + 16'(p));
        run_to_output();
        for (int j = 0; j < N; j++)
            check_line(j, 1'b1, 16'hD000 + 16'(j ^ t), "R8 common tag delivered");
        check_blk('0, "R8 no block");
    endtask

    task automatic t_swap();
        @(negedge clk);
        offer(0, 0, 1, 16'hE001);
        offer(1, 1, 0, 16'hE100);
        run_to_output();
        check_line(1, 1'b1, 16'hE001, "R9 swap 0->1");
        check_line(0, 1'b1, 16'hE100, "R9 swap 1->0");
        check_blk('0, "R9 no block");
    endtask

    task automatic t_invalid();
        @(negedge clk);
        offer(2, 2, 7, 16'hF2F2);
        offer(7, 7, 7, 16'hF7F7);
        in_valid = '0;
        run_to_output();
        check_idle("R10 invalid lines silent");
    endtask

    initial begin
        t_reset();
        t_example();
        t_self();
        t_src_mismatch();
        t_collide(0);
        t_collide(1);
        t_collide(2);
        t_full_load(5);
        t_full_load(0);
        t_swap();
        t_invalid();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule